// File: doc/BRIEF.md
# Dual-Slot In-Order Dispatch Control

This block decides, every cycle, which of the two oldest entries of an instruction queue leave the queue. Slot 0 holds the older instruction and slot 1 the younger one. For each slot, the caller supplies:

- a valid bit,
- an instruction class,
- the number of rename registers the instruction needs,
- a serialize flag.

The caller also supplies the busy state of each execution unit, the number of free rename registers and the number of free completion-queue entries. The block answers purely combinationally, in the same cycle. Per slot, it reports whether the instruction leaves the queue, whether it is issued to an execution unit, whether it takes a completion-queue entry, and whether it was folded away. It also gives a 2-bit count by which the queue shifts down.

Ordinary instructions need their unit, their rename registers and one completion entry. A branch that writes the link or count register takes a completion entry, so those registers update in order, but it is never sent to a unit. Any other branch is folded out of the stream and uses no resources. The younger slot never leaves ahead of the older one.

Top module: `dual_dispatch`

## Requirements
- R1: Slot 1 is dispatched only in a cycle in which slot 0 is also dispatched.
- R2: An instruction of a unit class dispatches only if the unit it needs is not busy. When it does dispatch, its issue output is 1. The unit classes are: integer (class 0, unit 0), floating point (class 1, unit 1), load/store (class 2, unit 2) and system (class 3, unit 3). `unit_busy[k]` is the busy bit of unit k.
- R3: When both slots need the same execution unit, only slot 0 may dispatch in that cycle.
- R4: Every dispatched non-folded instruction takes one completion-queue entry. The number of entries taken in a cycle never exceeds `cq_free`.
- R5: The rename-register needs of the dispatched non-folded instructions add up to no more than `rn_free`.
- R6: A serializing instruction (serialize flag 1, not a folded branch) dispatches only from slot 0, and only when `cq_free` equals `CQ_DEPTH` (completion queue empty). Slot 1 does not dispatch in the same cycle.
- R7: A branch that writes the link or count register (class 4) dispatches without regard to unit busy bits. It takes a completion entry (`cq_alloc` 1) and has `issue` 0.
- R8: A folded branch (class 5) is dispatched with `fold` 1, `cq_alloc` 0 and `issue` 0, whatever the resource counts and busy bits are.
- R9: `disp_cnt` equals the number of slots dispatched in the cycle: 0, 1 or 2.
- R10: An invalid slot, or one with a reserved class (6 or 7), is never dispatched. It also blocks slot 1 when it sits in slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| slot_vld | input | 2 | Valid bit per slot |
| slot0_cls | input | 3 | Class of the slot 0 instruction |
| slot1_cls | input | 3 | Class of the slot 1 instruction |
| slot0_rn_need | input | RN_NEED_W | Rename registers needed by slot 0 |
| slot1_rn_need | input | RN_NEED_W | Rename registers needed by slot 1 |
| slot_ser | input | 2 | Serialize flag per slot |
| unit_busy | input | 4 | Busy bit per execution unit |
| rn_free | input | $clog2(RN_COUNT+1) | Free rename registers |
| cq_free | input | $clog2(CQ_DEPTH+1) | Free completion-queue entries |
| disp | output | 2 | Slot leaves the queue this cycle |
| issue | output | 2 | Slot is sent to its execution unit |
| cq_alloc | output | 2 | Slot takes a completion-queue entry |
| fold | output | 2 | Slot is a folded branch removed from the stream |
| disp_cnt | output | 2 | Number of slots that leave the queue |

## Verification
The bench builds the block with its defaults: a completion queue of 6 entries, 8 rename registers and rename needs of up to 3 per slot. At these sizes the bench can drive every free-entry count directly. This covers the exactly-empty queue that a serializing instruction needs, the single free entry that lets only slot 0 through, and rename demands that fit one slot but not both.

// File: rtl/dd_pkg.sv
package dd_pkg;
    // Instruction classes seen at the bottom of the queue
    typedef enum logic [2:0] {
        CLS_INT     = 3'd0,
        CLS_FP      = 3'd1,
        CLS_LSU     = 3'd2,
        CLS_SYS     = 3'd3,
        CLS_BR_LINK = 3'd4,
        CLS_BR_FOLD = 3'd5,
        CLS_RSV6    = 3'd6,
        CLS_RSV7    = 3'd7
    } iclass_e;

    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = $clog2(NUM_UNITS);
endpackage

// File: rtl/dd_slot_decode.sv
// dd_slot_decode: turns one queue slot into its resource demands.
// Assumes unit classes map one-to-one onto unit indices 0..NUM_UNITS-1.
module dd_slot_decode
    import dd_pkg::*;
#(
    parameter int RN_NEED_W = 2
) (
    input  logic                 vld,
    input  logic [2:0]           cls,
    input  logic [RN_NEED_W-1:0] rn_need,
    input  logic                 ser,
    output logic                 live,
    output logic                 is_fold,
    output logic                 needs_unit,
    output logic [UNIT_W-1:0]    unit_idx,
    output logic                 needs_cq,
    output logic [RN_NEED_W-1:0] rn_req,
    output logic                 ser_eff
);
    iclass_e c;

    // Classify the slot and derive what it consumes
    always_comb begin
        c          = iclass_e'(cls);
        live       = 1'b0;
        is_fold    = 1'b0;
        needs_unit = 1'b0;
        unit_idx   = '0;
        needs_cq   = 1'b0;
        case (c)
            CLS_INT, CLS_FP, CLS_LSU, CLS_SYS: begin
                live       = vld;
                needs_unit = 1'b1;
                unit_idx   = UNIT_W'(cls);
                needs_cq   = 1'b1;
            end
            CLS_BR_LINK: begin
                live     = vld;
                needs_cq = 1'b1;
            end
            CLS_BR_FOLD: begin
                live    = vld;
                is_fold = 1'b1;
            end
            default: live = 1'b0;
        endcase
        rn_req  = is_fold ? '0 : rn_need;
        ser_eff = ser & ~is_fold;
    end
endmodule

// File: rtl/dd_grant.sv
// dd_grant: in-order grant of the two slots against shared resources.
// Assumes slot 0 is the older instruction; slot 1 only follows slot 0.
module dd_grant
    import dd_pkg::*;
#(
    parameter int CQ_DEPTH  = 6,
    parameter int RN_COUNT  = 8,
    parameter int RN_NEED_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    live,
    input  logic [1:0]                    is_fold,
    input  logic [1:0]                    needs_unit,
    input  logic [UNIT_W-1:0]             unit_idx0,
    input  logic [UNIT_W-1:0]             unit_idx1,
    input  logic [1:0]                    needs_cq,
    input  logic [RN_NEED_W-1:0]          rn_req0,
    input  logic [RN_NEED_W-1:0]          rn_req1,
    input  logic [1:0]                    ser_eff,
    input  logic [NUM_UNITS-1:0]          unit_busy,
    input  logic [$clog2(RN_COUNT+1)-1:0] rn_free,
    input  logic [$clog2(CQ_DEPTH+1)-1:0] cq_free,
    output logic [1:0]                    disp,
    output logic [1:0]                    issue,
    output logic [1:0]                    cq_alloc,
    output logic [1:0]                    fold
);
    localparam int CQ_W = $clog2(CQ_DEPTH+1);
    localparam int RN_W = $clog2(RN_COUNT+1);
    localparam int SW   = ((RN_W > RN_NEED_W) ? RN_W : RN_NEED_W) + 1;
    localparam int CW   = CQ_W + 1;

    logic          cq_empty;
    logic          ok0, ok1, unit_ok0, unit_ok1;
    logic [SW-1:0] rn0_x, rn1_x, rn_free_x;
    logic [CW-1:0] cq_need1, cq_free_x;

    // Slot 0 grant: needs only the resources for itself
    always_comb begin
        cq_empty  = (cq_free == CQ_W'(CQ_DEPTH));
        rn0_x     = SW'(rn_req0);
        rn_free_x = SW'(rn_free);
        unit_ok0  = ~needs_unit[0] | ~unit_busy[unit_idx0];
        ok0 = live[0] & (is_fold[0] |
              ((cq_free != '0) & (rn0_x <= rn_free_x) & unit_ok0 &
               (~ser_eff[0] | cq_empty)));
    end

    // Slot 1 grant: resources left after slot 0, never ahead of it
    always_comb begin
        rn1_x     = SW'(rn_req0) + SW'(rn_req1);
        cq_free_x = CW'(cq_free);
        cq_need1  = CW'(needs_cq[0]) + CW'(1);
        unit_ok1  = ~needs_unit[1] |
                    (~unit_busy[unit_idx1] &
                     ~(needs_unit[0] & (unit_idx0 == unit_idx1)));
        ok1 = ok0 & live[1] & ~ser_eff[0] & (is_fold[1] |
              (~ser_eff[1] & (cq_need1 <= cq_free_x) &
               (rn1_x <= rn_free_x) & unit_ok1));
    end

    // Per-slot outputs derived from the grants
    always_comb begin
        disp     = {ok1, ok0};
        issue    = disp & needs_unit;
        cq_alloc = disp & needs_cq;
        fold     = disp & is_fold;
    end

    // A granted unit is never busy
    p_unit_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue[0] |-> !unit_busy[unit_idx0]) and (issue[1] |-> !unit_busy[unit_idx1]));
    // Two issues in one cycle go to different units
    p_unit_conflict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue == 2'b11) |-> (unit_idx0 != unit_idx1));
    // Rename demand of the granted slots fits the free pool
    p_rn_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((disp[0] ? SW'(rn_req0) : SW'(0)) + (disp[1] ? SW'(rn_req1) : SW'(0))) <= rn_free_x);
endmodule

// File: rtl/dual_dispatch.sv
// dual_dispatch: top of the two-slot in-order dispatch control.
// Purely combinational grant; clk/rst_n only time the embedded checks.
// Assumes the caller shifts the queue by disp_cnt and updates free counts.
module dual_dispatch
    import dd_pkg::*;
#(
    parameter int CQ_DEPTH  = 6,
    parameter int RN_COUNT  = 8,
    parameter int RN_NEED_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    slot_vld,
    input  logic [2:0]                    slot0_cls,
    input  logic [2:0]                    slot1_cls,
    input  logic [RN_NEED_W-1:0]          slot0_rn_need,
    input  logic [RN_NEED_W-1:0]          slot1_rn_need,
    input  logic [1:0]                    slot_ser,
    input  logic [NUM_UNITS-1:0]          unit_busy,
    input  logic [$clog2(RN_COUNT+1)-1:0] rn_free,
    input  logic [$clog2(CQ_DEPTH+1)-1:0] cq_free,
    output logic [1:0]                    disp,
    output logic [1:0]                    issue,
    output logic [1:0]                    cq_alloc,
    output logic [1:0]                    fold,
    output logic [1:0]                    disp_cnt
);
    localparam int NSLOT = 2;
    localparam int CQ_W  = $clog2(CQ_DEPTH+1);

    logic [2:0]           cls_a    [NSLOT];
    logic [RN_NEED_W-1:0] need_a   [NSLOT];
    logic [UNIT_W-1:0]    uidx_a   [NSLOT];
    logic [RN_NEED_W-1:0] rnreq_a  [NSLOT];
    logic [NSLOT-1:0]     live, is_fold, needs_unit, needs_cq, ser_eff;

    // Gather per-slot inputs into arrays for the decode loop
    always_comb begin
        cls_a[0]  = slot0_cls;
        cls_a[1]  = slot1_cls;
        need_a[0] = slot0_rn_need;
        need_a[1] = slot1_rn_need;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_dec
        dd_slot_decode #(.RN_NEED_W(RN_NEED_W)) u_dec (
            .vld        (slot_vld[s]),
            .cls        (cls_a[s]),
            .rn_need    (need_a[s]),
            .ser        (slot_ser[s]),
            .live       (live[s]),
            .is_fold    (is_fold[s]),
            .needs_unit (needs_unit[s]),
            .unit_idx   (uidx_a[s]),
            .needs_cq   (needs_cq[s]),
            .rn_req     (rnreq_a[s]),
            .ser_eff    (ser_eff[s])
        );
    end

    dd_grant #(
        .CQ_DEPTH  (CQ_DEPTH),
        .RN_COUNT  (RN_COUNT),
        .RN_NEED_W (RN_NEED_W)
    ) u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .live       (live),
        .is_fold    (is_fold),
        .needs_unit (needs_unit),
        .unit_idx0  (uidx_a[0]),
        .unit_idx1  (uidx_a[1]),
        .needs_cq   (needs_cq),
        .rn_req0    (rnreq_a[0]),
        .rn_req1    (rnreq_a[1]),
        .ser_eff    (ser_eff),
        .unit_busy  (unit_busy),
        .rn_free    (rn_free),
        .cq_free    (cq_free),
        .disp       (disp),
        .issue      (issue),
        .cq_alloc   (cq_alloc),
        .fold       (fold)
    );

    // Queue shift-down amount
    always_comb disp_cnt = {1'b0, disp[0]} + {1'b0, disp[1]};

    // Younger slot never leaves alone
    p_in_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        disp[1] |-> disp[0]);
    // Completion entries taken fit the free count
    p_cq_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cq_alloc) <= int'(cq_free)));
    // Serializing slot 0 needs an empty queue and goes alone
    p_serialize_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (disp[0] && slot_ser[0] && !is_fold[0]) |->
            (cq_free == CQ_W'(CQ_DEPTH) && !disp[1]));
    // A serializing younger slot never dispatches
    p_ser_slot1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_ser[1] && !is_fold[1]) |-> !disp[1]);
    // Link/count branch takes an entry but is not issued
    p_link_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp[0] && slot0_cls == 3'd4) |-> (cq_alloc[0] && !issue[0]));
    // Folded slots use nothing
    p_fold_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((fold & (issue | cq_alloc)) == 2'b00));
    // Shift amount never exceeds the slot count
    p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_cnt != 2'd3));
endmodule

// File: tb/dual_dispatch_tb.sv
module dual_dispatch_tb;
    localparam int CQ_DEPTH  = 6;
    localparam int RN_COUNT  = 8;
    localparam int RN_NEED_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] slot_vld = '0, slot_ser = '0;
    logic [2:0] slot0_cls = '0, slot1_cls = '0;
    logic [1:0] slot0_rn_need = '0, slot1_rn_need = '0;
    logic [3:0] unit_busy = '0;
    logic [3:0] rn_free = '0;
    logic [2:0] cq_free = '0;
    logic [1:0] disp, issue, cq_alloc, fold, disp_cnt;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_dispatch #(.CQ_DEPTH(CQ_DEPTH), .RN_COUNT(RN_COUNT), .RN_NEED_W(RN_NEED_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot0_cls(slot0_cls),
        .slot1_cls(slot1_cls), .slot0_rn_need(slot0_rn_need), .slot1_rn_need(slot1_rn_need),
        .slot_ser(slot_ser), .unit_busy(unit_busy), .rn_free(rn_free), .cq_free(cq_free),
        .disp(disp), .issue(issue), .cq_alloc(cq_alloc), .fold(fold), .disp_cnt(disp_cnt)
    );

    // Drive one cycle of inputs at the falling edge
    task automatic drive(input logic [1:0] v, input logic [2:0] c0, input logic [2:0] c1,
                         input logic [1:0] r0, input logic [1:0] r1, input logic [1:0] s,
                         input logic [3:0] busy, input logic [3:0] rnf, input logic [2:0] cqf);
        @(negedge clk);
        slot_vld = v; slot0_cls = c0; slot1_cls = c1;
        slot0_rn_need = r0; slot1_rn_need = r1; slot_ser = s;
        unit_busy = busy; rn_free = rnf; cq_free = cqf;
        #2;
    endtask

    // Compare all outputs against the expected vector
    task automatic check(input string req, input logic [1:0] e_disp, input logic [1:0] e_issue,
                         input logic [1:0] e_cq, input logic [1:0] e_fold, input logic [1:0] e_cnt);
        n_checks++;
        if ({disp, issue, cq_alloc, fold, disp_cnt} !== {e_disp, e_issue, e_cq, e_fold, e_cnt}) begin
            n_errors++;
            $display("FAIL %s: disp/issue/cq/fold/cnt got %b/%b/%b/%b/%0d expected %b/%b/%b/%b/%0d",
                     req, disp, issue, cq_alloc, fold, disp_cnt, e_disp, e_issue, e_cq, e_fold, e_cnt);
        end
    endtask

    task automatic t_reset_idle;
        drive(2'b00, 3'd0, 3'd0, 0, 0, 0, 4'h0, 4'd8, 3'd6);
        check("R10 idle", 2'b00, 2'b00, 2'b00, 2'b00, 2'd0);
    endtask

    task automatic t_units;
        drive(2'b11, 3'd0, 3'd1, 0, 0, 0, 4'h0, 4'd8, 3'd6);
        check("R2 R9 int+fp", 2'b11, 2'b11, 2'b11, 2'b00, 2'd2);
        drive(2'b11, 3'd2, 3'd2, 0, 0, 0, 4'h0, 4'd8, 3'd6);
        check("R3 same unit", 2'b01, 2'b01, 2'b01, 2'b00, 2'd1);
        drive(2'b11, 3'd0, 3'd1, 0, 0, 0, 4'b0001, 4'd8, 3'd6);
        check("R1 slot0 busy", 2'b00, 2'b00, 2'b00, 2'b00, 2'd0);
        drive(2'b11, 3'd3, 3'd1, 0, 0, 0, 4'b0010, 4'd8, 3'd6);
        check("R2 slot1 busy", 2'b01, 2'b01, 2'b01, 2'b00, 2'd1);
    endtask

    task automatic t_cq;
        drive(2'b11, 3'd0, 3'd1, 0, 0, 0, 4'h0, 4'd8, 3'd1);
        check("R4 one entry", 2'b01, 2'b01, 2'b01, 2'b00, 2'd1);
        drive(2'b11, 3'd0, 3'd1, 0, 0, 0, 4'h0, 4'd8, 3'd0);
        check("R4 no entry", 2'b00, 2'b00, 2'b00, 2'b00, 2'd0);
    endtask

    task automatic t_rename;
        drive(2'b11, 3'd0, 3'd1, 2, 2, 0, 4'h0, 4'd3, 3'd6);
        check("R5 over", 2'b01, 2'b01, 2'b01, 2'b00, 2'd1);
        drive(2'b11, 3'd0, 3'd1, 2, 1, 0, 4'h0, 4'd3, 3'd6);
        check("R5 exact", 2'b11, 2'b11, 2'b11, 2'b00, 2'd2);
        drive(2'b01, 3'd0, 3'd1, 3, 0, 0, 4'h0, 4'd2, 3'd6);
        check("R5 slot0 short", 2'b00, 2'b00, 2'b00, 2'b00, 2'd0);
    endtask

    task automatic t_serialize;
        drive(2'b11, 3'd3, 3'd0, 0, 0, 2'b01, 4'h0, 4'd8, 3'd6);
        check("R6 empty queue", 2'b01, 2'b01, 2'b01, 2'b00, 2'd1);
        drive(2'b11, 3'd3, 3'd0, 0, 0, 2'b01, 4'h0, 4'd8, 3'd5);
        check("R6 not empty", 2'b00, 2'b00, 2'b00, 2'b00, 2'd0);
        drive(2'b11, 3'd0, 3'd1, 0, 0, 2'b10, 4'h0, 4'd8, 3'd6);
        check("R6 slot1 ser", 2'b01, 2'b01, 2'b01, 2'b00, 2'd1);
    endtask

    task automatic t_link;
        drive(2'b11, 3'd4, 3'd4, 0, 0, 0, 4'hF, 4'd8, 3'd6);
        check("R7 link pair", 2'b11, 2'b00, 2'b11, 2'b00, 2'd2);
        drive(2'b01, 3'd4, 3'd0, 0, 0, 0, 4'h0, 4'd8, 3'd0);
        check("R7 link no entry", 2'b00, 2'b00, 2'b00, 2'b00, 2'd0);
    endtask

    task automatic t_fold;
        drive(2'b11, 3'd5, 3'd5, 3, 3, 2'b11, 4'hF, 4'd0, 3'd0);
        check("R8 fold pair", 2'b11, 2'b00, 2'b00, 2'b11, 2'd2);
        drive(2'b11, 3'd0, 3'd5, 0, 0, 0, 4'b0001, 4'd8, 3'd6);
        check("R8 R1 fold behind busy", 2'b00, 2'b00, 2'b00, 2'b00, 2'd0);
        drive(2'b11, 3'd5, 3'd1, 0, 1, 0, 4'h0, 4'd1, 3'd1);
        check("R8 fold then fp", 2'b11, 2'b10, 2'b10, 2'b01, 2'd2);
    endtask

    task automatic t_reserved;
        drive(2'b11, 3'd6, 3'd0, 0, 0, 0, 4'h0, 4'd8, 3'd6);
        check("R10 reserved slot0", 2'b00, 2'b00, 2'b00, 2'b00, 2'd0);
        drive(2'b11, 3'd1, 3'd7, 0, 0, 0, 4'h0, 4'd8, 3'd6);
        check("R10 reserved slot1", 2'b01, 2'b01, 2'b01, 2'b00, 2'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_units();
        t_cq();
        t_rename();
        t_serialize();
        t_link();
        t_fold();
        t_reserved();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule